// File: doc/BRIEF.md
# I2C Transaction Frame Sequencer

This block sits between a host command parser and a byte-level I2C master engine. The parser hands it transfer frames: a start marker carrying a slave address byte and a byte count, then the payload bytes of a write frame, and an end marker when the host closes the transfer. The sequencer turns each frame into an ordered list of bus primitives: start condition, address byte, write byte, read byte with acknowledge choice, repeated start and stop. It issues them one at a time over a valid/done handshake. Bytes read from the slave go straight back to the host transmit path.

A new start marker that arrives before the end marker chains the next transfer behind a repeated start, so a read can follow a write without freeing the bus. A slave that refuses the address or a written byte ends the transfer early. The sequencer then closes the bus, discards the rest of that frame, and raises a sticky error flag until the register side clears it.

Top module: `i2c_frame_seq`

## Requirements
- R1: While reset is held and in the cycle after it, `eng_cmd_valid`, `host_rvalid`, `err_flag` and `fr_wready` are all 0.
- R2: A frame whose address bit 0 is 0 and whose count N is greater than 0 issues START (code 1), ADDR (code 3) carrying the address byte, and then N WRITE primitives (code 4). The WRITE primitives carry the payload bytes in the order they were accepted on `fr_wvalid`/`fr_wready`.
- R3: A frame whose address bit 0 is 1 issues START, ADDR and then exactly N READ primitives (code 5). `eng_ack_rd` is 1 on every READ except the last, where it is 0. Each byte read is presented on `host_rdata` with `host_rvalid` high in the cycle after that READ completes.
- R4: A count of 0 issues only START and ADDR, followed by STOP (code 6) once the end marker is seen.
- R5: An end marker after a frame makes STOP the next primitive once the frame's last primitive completes. A start marker received after a frame but before any end marker makes RSTART (code 2) the next primitive instead, and no STOP comes between the two transfers.
- R6: A completion with `eng_nack` high on an ADDR or WRITE primitive is followed directly by STOP. No further byte primitives are issued for that frame, and its remaining payload bytes and its end marker are taken in without producing any primitive. The next frame then begins with START.
- R7: `err_flag` goes to 1 in the cycle after a refused ADDR or WRITE completes. It stays at 1 until `err_clr` is pulsed while no refusal is completing.
- R8: Only one primitive is outstanding at a time. While `eng_cmd_valid` is high and `eng_done` is low, `eng_cmd`, `eng_wdata` and `eng_ack_rd` hold their values. `fr_wready` is high only while no primitive is outstanding.
- R9: An end marker that arrives while no transfer is open produces no primitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fr_start | input | 1 | One-cycle pulse: start marker with address and count |
| fr_addr | input | 8 | Slave address byte, bit 0 gives direction (1 = read) |
| fr_count | input | CNT_W | Number of bytes to transfer |
| fr_stop | input | 1 | One-cycle pulse: end marker |
| fr_wvalid | input | 1 | Payload byte available |
| fr_wdata | input | 8 | Payload byte |
| fr_wready | output | 1 | Payload byte taken this cycle when valid |
| eng_cmd_valid | output | 1 | Primitive outstanding toward the bit engine |
| eng_cmd | output | 3 | Primitive code: 1 START, 2 RSTART, 3 ADDR, 4 WRITE, 5 READ, 6 STOP |
| eng_wdata | output | 8 | Byte for ADDR and WRITE |
| eng_ack_rd | output | 1 | For READ: 1 = acknowledge the byte, 0 = refuse it |
| eng_done | input | 1 | One-cycle completion of the outstanding primitive |
| eng_nack | input | 1 | With done: the slave refused ADDR or WRITE |
| eng_rdata | input | 8 | With done: byte read by a READ |
| host_rvalid | output | 1 | Read byte for the host is valid |
| host_rdata | output | 8 | Read byte for the host |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky refusal flag |

## Verification
A completion on `eng_done` is answered at the next rising edge. The following primitive, a returned read byte or the error flag therefore appears one cycle after the completion. A payload byte taken on `fr_wready` shows up as a WRITE primitive in the cycle after it is taken. The bench drives its inputs and samples every output on the falling edge. A behavioural bit-engine model sees each new primitive on the falling edge right after it appears and compares it with the list of primitives predicted from the frames sent. That model answers after a fixed delay and checks the held fields on every falling edge in between. Read bytes are matched one falling edge after the completion that produced them.

// File: rtl/i2cseq_pkg.sv
// Shared types for the I2C transaction frame sequencer.
package i2cseq_pkg;

    // Primitive codes seen by the bit engine; values are part of the port contract.
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_ADDR   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_READ   = 3'd5,
        OP_STOP   = 3'd6
    } op_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COND,
        ST_ADDR,
        ST_FETCH,
        ST_DATA,
        ST_HOLD,
        ST_STOP,
        ST_DRAIN
    } st_e;

    // One primitive with its operands.
    typedef struct packed {
        op_e        op;
        logic [7:0] data;
        logic       ack;
    } prim_t;

endpackage

// File: rtl/i2cseq_req_latch.sv
// Captures start and end markers from the parser until the controller takes them.
// Assumes at most one start marker is pending at a time. stop_first records that
// the pending end marker precedes the pending start marker in host order.
module i2cseq_req_latch #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fr_start,
    input  logic [7:0]       fr_addr,
    input  logic [CNT_W-1:0] fr_count,
    input  logic             fr_stop,
    input  logic             take_start,
    input  logic             take_stop,
    output logic             pend_start,
    output logic [7:0]       pend_addr,
    output logic [CNT_W-1:0] pend_count,
    output logic             pend_stop,
    output logic             stop_first
);

    // Pending start marker with its address and count; a new marker wins over a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_start <= 1'b0;
            pend_addr  <= '0;
            pend_count <= '0;
        end else if (fr_start) begin
            pend_start <= 1'b1;
            pend_addr  <= fr_addr;
            pend_count <= fr_count;
        end else if (take_start) begin
            pend_start <= 1'b0;
        end
    end

    // Pending end marker and whether it belongs before the pending start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_stop  <= 1'b0;
            stop_first <= 1'b0;
        end else if (fr_stop) begin
            pend_stop  <= 1'b1;
            stop_first <= !pend_start || take_start;
        end else if (take_stop) begin
            pend_stop  <= 1'b0;
            stop_first <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cseq_prim_port.sv
// Holds the one outstanding primitive toward the bit engine.
// A load takes priority over a completion, so back-to-back primitives keep
// valid high and change operands in the cycle after the done pulse.
module i2cseq_prim_port
    import i2cseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  prim_t load_prim,
    input  logic  eng_done,
    output logic  cmd_valid,
    output prim_t cmd
);

    // Valid flag and operand register for the outstanding primitive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd       <= '{op: OP_NONE, data: 8'h00, ack: 1'b0};
        end else if (load) begin
            cmd_valid <= 1'b1;
            cmd       <= load_prim;
        end else if (eng_done) begin
            cmd_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cseq_ctrl.sv
// Frame sequencer state machine. It walks start, address and data primitives
// for the current frame, then chooses stop or repeated start from the pending
// markers. It aborts on a refused address or write byte, and drains the rest of
// an aborted frame. Assumes the payload of an aborted frame reaches fr_wvalid
// before that frame's end marker.
module i2cseq_ctrl
    import i2cseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_start,
    input  logic [7:0]       pend_addr,
    input  logic [CNT_W-1:0] pend_count,
    input  logic             pend_stop,
    input  logic             stop_first,
    output logic             take_start,
    output logic             take_stop,
    input  logic             fr_wvalid,
    input  logic [7:0]       fr_wdata,
    output logic             fr_wready,
    output logic             prim_load,
    output prim_t            prim_next,
    input  logic             cmd_valid,
    input  logic             eng_done,
    input  logic             eng_nack,
    input  logic [7:0]       eng_rdata,
    output logic             host_rvalid,
    output logic [7:0]       host_rdata,
    input  logic             err_clr,
    output logic             err_flag
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

    st_e              state, nstate;
    logic [7:0]       cur_addr;
    logic [CNT_W-1:0] remain;
    logic             aborting;
    logic             load_cur, dec_remain, abort_go, done_ok, stop_due, is_read;

    assign done_ok  = eng_done && cmd_valid;
    assign stop_due = pend_stop && (stop_first || !pend_start);
    assign is_read  = cur_addr[0];

    // Next state and the primitive to load, chosen from state and engine response.
    always_comb begin
        nstate     = state;
        take_start = 1'b0;
        take_stop  = 1'b0;
        fr_wready  = 1'b0;
        prim_load  = 1'b0;
        prim_next  = '{op: OP_NONE, data: 8'h00, ack: 1'b0};
        load_cur   = 1'b0;
        dec_remain = 1'b0;
        abort_go   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (stop_due) begin
                    take_stop = 1'b1;
                end else if (pend_start) begin
                    take_start     = 1'b1;
                    load_cur       = 1'b1;
                    prim_load      = 1'b1;
                    prim_next.op   = OP_START;
                    nstate         = ST_COND;
                end
            end
            ST_COND: begin
                if (done_ok) begin
                    prim_load      = 1'b1;
                    prim_next.op   = OP_ADDR;
                    prim_next.data = cur_addr;
                    nstate         = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (done_ok) begin
                    if (eng_nack) begin
                        abort_go = 1'b1;
                    end else if (remain == '0) begin
                        nstate = ST_HOLD;
                    end else if (is_read) begin
                        prim_load     = 1'b1;
                        prim_next.op  = OP_READ;
                        prim_next.ack = (remain != CNT_ONE);
                        nstate        = ST_DATA;
                    end else begin
                        nstate = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                fr_wready = 1'b1;
                if (fr_wvalid) begin
                    prim_load      = 1'b1;
                    prim_next.op   = OP_WRITE;
                    prim_next.data = fr_wdata;
                    nstate         = ST_DATA;
                end
            end
            ST_DATA: begin
                if (done_ok) begin
                    if (!is_read && eng_nack) begin
                        abort_go = 1'b1;
                    end else begin
                        dec_remain = 1'b1;
                        if (remain == CNT_ONE) begin
                            nstate = ST_HOLD;
                        end else if (is_read) begin
                            prim_load     = 1'b1;
                            prim_next.op  = OP_READ;
                            prim_next.ack = (remain != CNT_TWO);
                        end else begin
                            nstate = ST_FETCH;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (stop_due) begin
                    take_stop    = 1'b1;
                    prim_load    = 1'b1;
                    prim_next.op = OP_STOP;
                    nstate       = ST_STOP;
                end else if (pend_start) begin
                    take_start   = 1'b1;
                    load_cur     = 1'b1;
                    prim_load    = 1'b1;
                    prim_next.op = OP_RSTART;
                    nstate       = ST_COND;
                end
            end
            ST_STOP: begin
                if (done_ok) begin
                    nstate = aborting ? ST_DRAIN : ST_IDLE;
                end
            end
            ST_DRAIN: begin
                fr_wready = !pend_start;
                if (stop_due && !(fr_wvalid && !pend_start)) begin
                    take_stop = 1'b1;
                    nstate    = ST_IDLE;
                end else if (pend_start && !stop_due) begin
                    take_start   = 1'b1;
                    load_cur     = 1'b1;
                    prim_load    = 1'b1;
                    prim_next.op = OP_START;
                    nstate       = ST_COND;
                end
            end
            default: nstate = ST_IDLE;
        endcase
        if (abort_go) begin
            prim_load    = 1'b1;
            prim_next    = '{op: OP_STOP, data: 8'h00, ack: 1'b0};
            nstate       = ST_STOP;
        end
    end

    // State, current frame address, bytes remaining and abort marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= 8'h00;
            remain   <= '0;
            aborting <= 1'b0;
        end else begin
            state <= nstate;
            if (load_cur) begin
                cur_addr <= pend_addr;
                remain   <= pend_count;
            end else if (dec_remain) begin
                remain <= remain - CNT_ONE;
            end
            if (abort_go) begin
                aborting <= 1'b1;
            end else if (load_cur) begin
                aborting <= 1'b0;
            end
        end
    end

    // Return path: one pulse per completed read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= 8'h00;
        end else begin
            host_rvalid <= done_ok && (state == ST_DATA) && is_read;
            if (done_ok && (state == ST_DATA) && is_read) begin
                host_rdata <= eng_rdata;
            end
        end
    end

    // Sticky refusal flag; a new refusal wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (abort_go) begin
            err_flag <= 1'b1;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_frame_seq.sv
// Top of the I2C transaction frame sequencer. It joins the marker latch, the
// controller and the primitive port. Assumes the bit engine returns one done
// pulse per primitive it sees valid.
module i2c_frame_seq
    import i2cseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fr_start,
    input  logic [7:0]       fr_addr,
    input  logic [CNT_W-1:0] fr_count,
    input  logic             fr_stop,
    input  logic             fr_wvalid,
    input  logic [7:0]       fr_wdata,
    output logic             fr_wready,
    output logic             eng_cmd_valid,
    output logic [2:0]       eng_cmd,
    output logic [7:0]       eng_wdata,
    output logic             eng_ack_rd,
    input  logic             eng_done,
    input  logic             eng_nack,
    input  logic [7:0]       eng_rdata,
    output logic             host_rvalid,
    output logic [7:0]       host_rdata,
    input  logic             err_clr,
    output logic             err_flag
);

    logic             pend_start, pend_stop, stop_first, take_start, take_stop;
    logic [7:0]       pend_addr;
    logic [CNT_W-1:0] pend_count;
    logic             prim_load;
    prim_t            prim_next, cmd;

    i2cseq_req_latch #(.CNT_W(CNT_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fr_start   (fr_start),
        .fr_addr    (fr_addr),
        .fr_count   (fr_count),
        .fr_stop    (fr_stop),
        .take_start (take_start),
        .take_stop  (take_stop),
        .pend_start (pend_start),
        .pend_addr  (pend_addr),
        .pend_count (pend_count),
        .pend_stop  (pend_stop),
        .stop_first (stop_first)
    );

    i2cseq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_start  (pend_start),
        .pend_addr   (pend_addr),
        .pend_count  (pend_count),
        .pend_stop   (pend_stop),
        .stop_first  (stop_first),
        .take_start  (take_start),
        .take_stop   (take_stop),
        .fr_wvalid   (fr_wvalid),
        .fr_wdata    (fr_wdata),
        .fr_wready   (fr_wready),
        .prim_load   (prim_load),
        .prim_next   (prim_next),
        .cmd_valid   (eng_cmd_valid),
        .eng_done    (eng_done),
        .eng_nack    (eng_nack),
        .eng_rdata   (eng_rdata),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata),
        .err_clr     (err_clr),
        .err_flag    (err_flag)
    );

    i2cseq_prim_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (prim_load),
        .load_prim (prim_next),
        .eng_done  (eng_done),
        .cmd_valid (eng_cmd_valid),
        .cmd       (cmd)
    );

    assign eng_cmd    = cmd.op;
    assign eng_wdata  = cmd.data;
    assign eng_ack_rd = cmd.ack;

endmodule

// File: rtl/i2cseq_chk.sv
// Protocol checker for the frame sequencer, attached to the top by bind.
module i2cseq_chk
    import i2cseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       eng_cmd_valid,
    input logic [2:0] eng_cmd,
    input logic [7:0] eng_wdata,
    input logic       eng_ack_rd,
    input logic       eng_done,
    input logic       eng_nack,
    input logic       host_rvalid,
    input logic       fr_wready,
    input logic       err_clr,
    input logic       err_flag
);

    logic refused;
    assign refused = eng_cmd_valid && eng_done && eng_nack &&
                     (eng_cmd == OP_ADDR || eng_cmd == OP_WRITE);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !eng_cmd_valid && !host_rvalid && !err_flag && !fr_wready);

    assert_read_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(eng_cmd_valid && eng_done && eng_cmd == OP_READ));

    assert_stop_on_refusal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> eng_cmd_valid && eng_cmd == OP_STOP);

    assert_err_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> err_flag);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clr |=> err_flag);

    assert_hold_operands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid && !eng_done |=> eng_cmd_valid && $stable(eng_cmd) &&
                                       $stable(eng_wdata) && $stable(eng_ack_rd));

    assert_fetch_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fr_wready |-> !eng_cmd_valid);

endmodule

bind i2c_frame_seq i2cseq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd       (eng_cmd),
    .eng_wdata     (eng_wdata),
    .eng_ack_rd    (eng_ack_rd),
    .eng_done      (eng_done),
    .eng_nack      (eng_nack),
    .host_rvalid   (host_rvalid),
    .fr_wready     (fr_wready),
    .err_clr       (err_clr),
    .err_flag      (err_flag)
);

// File: tb/sim_i2c_frame_seq.sv
// Bench: behavioural bit engine plus a predicted-primitive list, compared every falling edge.
module sim_i2c_frame_seq;

    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fr_start = 1'b0, fr_stop = 1'b0, fr_wvalid = 1'b0, err_clr = 1'b0;
    logic [7:0] fr_addr = 8'h00, fr_wdata = 8'h00;
    logic [7:0] fr_count = 8'h00;
    logic       eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0] eng_rdata = 8'h00;
    logic       fr_wready, eng_cmd_valid, eng_ack_rd, host_rvalid, err_flag;
    logic [2:0] eng_cmd;
    logic [7:0] eng_wdata, host_rdata;

    int checks = 0, errors = 0;
    int exp_op[$];
    int exp_dat[$];
    int exp_ack[$];
    string exp_tag[$];
    logic [7:0] exp_rd[$];
    logic [7:0] wq[$];
    int cmd_seen = 0;
    bit cur = 0, acc_prev = 0, nack_addr = 0;
    int timer = 0, cur_op = 0, cur_dat = 0, cur_ack = 0;
    int wr_idx = 0, nack_wr = -1;
    logic [7:0] rd_seed = 8'h3C;

    i2c_frame_seq u0 (
        .clk(clk), .rst_n(rst_n), .fr_start(fr_start), .fr_addr(fr_addr),
        .fr_count(fr_count), .fr_stop(fr_stop), .fr_wvalid(fr_wvalid),
        .fr_wdata(fr_wdata), .fr_wready(fr_wready), .eng_cmd_valid(eng_cmd_valid),
        .eng_cmd(eng_cmd), .eng_wdata(eng_wdata), .eng_ack_rd(eng_ack_rd),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .err_clr(err_clr),
        .err_flag(err_flag)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_prim(input int op, input int dat, input int ack, input string tag);
        exp_op.push_back(op);
        exp_dat.push_back(dat);
        exp_ack.push_back(ack);
        exp_tag.push_back(tag);
    endtask

    // Engine model, payload feeder and output comparison on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (eng_done) begin
                eng_done = 1'b0;
                eng_nack = 1'b0;
                cur = 0;
            end
            if (eng_cmd_valid && !cur) begin
                cur = 1;
                timer = LAT;
                cur_op = int'(eng_cmd);
                cur_dat = int'(eng_wdata);
                cur_ack = int'(eng_ack_rd);
                cmd_seen++;
                if (exp_op.size() == 0) begin
                    chk(0, "R9 unexpected primitive", cur_op, 0);
                end else begin
                    chk(cur_op == exp_op[0], {exp_tag[0], " primitive code"}, cur_op, exp_op[0]);
                    if (exp_op[0] == 3 || exp_op[0] == 4)
                        chk(cur_dat == exp_dat[0], {exp_tag[0], " primitive byte"}, cur_dat, exp_dat[0]);
                    if (exp_op[0] == 5)
                        chk(cur_ack == exp_ack[0], {exp_tag[0], " read ack choice"}, cur_ack, exp_ack[0]);
                    void'(exp_op.pop_front());
                    void'(exp_dat.pop_front());
                    void'(exp_ack.pop_front());
                    void'(exp_tag.pop_front());
                end
            end else if (cur) begin
                chk(eng_cmd_valid && int'(eng_cmd) == cur_op && int'(eng_wdata) == cur_dat,
                    "R8 operands held", int'(eng_cmd), cur_op);
                timer--;
                if (timer == 0) begin
                    eng_done = 1'b1;
                    if (cur_op == 3) eng_nack = nack_addr;
                    if (cur_op == 4) begin
                        eng_nack = (wr_idx == nack_wr);
                        wr_idx++;
                    end
                    if (cur_op == 5) begin
                        eng_rdata = rd_seed;
                        exp_rd.push_back(rd_seed);
                        rd_seed = rd_seed + 8'h13;
                    end
                end
            end
            if (host_rvalid) begin
                if (exp_rd.size() == 0) chk(0, "R3 unexpected host byte", host_rdata, 0);
                else chk(host_rdata == exp_rd.pop_front(), "R3 host byte", host_rdata, 0);
            end
            if (acc_prev) void'(wq.pop_front());
            fr_wvalid = (wq.size() > 0);
            fr_wdata  = fr_wvalid ? wq[0] : 8'h00;
            acc_prev  = fr_wvalid && fr_wready;
        end
    end

    task automatic send_start(input logic [7:0] a, input int n, input logic [7:0] base);
        @(negedge clk);
        fr_start = 1'b1;
        fr_addr  = a;
        fr_count = 8'(n);
        if (!a[0]) for (int i = 0; i < n; i++) wq.push_back(base + 8'(i));
        @(negedge clk);
        fr_start = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk);
        fr_stop = 1'b1;
        @(negedge clk);
        fr_stop = 1'b0;
    endtask

    task automatic settle();
        while (exp_op.size() != 0 || eng_cmd_valid || wq.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        chk(exp_op.size() == 0, "R5 all predicted primitives issued", exp_op.size(), 0);
        chk(exp_rd.size() == 0, "R3 all read bytes returned", exp_rd.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired actual=%0d expected=0", exp_op.size());
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        chk(!eng_cmd_valid && !host_rvalid && !err_flag && !fr_wready, "R1 outputs in reset",
            {eng_cmd_valid, host_rvalid, err_flag, fr_wready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!eng_cmd_valid && !err_flag && !fr_wready, "R1 outputs after reset",
            {eng_cmd_valid, err_flag, fr_wready}, 0);

        // R2: write of three bytes, closed by the end marker.
        expect_prim(1, 0, 0, "R2");
        expect_prim(3, 8'h50, 0, "R2");
        for (int i = 0; i < 3; i++) expect_prim(4, 8'hA0 + i, 0, "R2");
        expect_prim(6, 0, 0, "R5");
        send_start(8'h50, 3, 8'hA0);
        send_stop();
        settle();

        // R3: read of two bytes, ack then refuse.
        expect_prim(1, 0, 0, "R3");
        expect_prim(3, 8'h51, 0, "R3");
        expect_prim(5, 0, 1, "R3");
        expect_prim(5, 0, 0, "R3");
        expect_prim(6, 0, 0, "R5");
        send_start(8'h51, 2, 8'h00);
        send_stop();
        settle();

        // R3 boundary: single-byte read is refused at once.
        expect_prim(1, 0, 0, "R3");
        expect_prim(3, 8'h61, 0, "R3");
        expect_prim(5, 0, 0, "R3");
        expect_prim(6, 0, 0, "R5");
        send_start(8'h61, 1, 8'h00);
        send_stop();
        settle();

        // R4: probe with zero count.
        expect_prim(1, 0, 0, "R4");
        expect_prim(3, 8'h20, 0, "R4");
        expect_prim(6, 0, 0, "R4");
        send_start(8'h20, 0, 8'h00);
        send_stop();
        settle();

        // R5: write then read chained with a repeated start.
        expect_prim(1, 0, 0, "R5");
        expect_prim(3, 8'h50, 0, "R5");
        expect_prim(4, 8'hC7, 0, "R5");
        expect_prim(2, 0, 0, "R5");
        expect_prim(3, 8'h51, 0, "R5");
        expect_prim(5, 0, 1, "R5");
        expect_prim(5, 0, 0, "R5");
        expect_prim(6, 0, 0, "R5");
        send_start(8'h50, 1, 8'hC7);
        send_start(8'h51, 2, 8'h00);
        send_stop();
        settle();
        chk(!err_flag, "R7 flag clear without refusal", err_flag, 0);

        // R6: address refused on a write frame.
        nack_addr = 1;
        expect_prim(1, 0, 0, "R6");
        expect_prim(3, 8'h40, 0, "R6");
        expect_prim(6, 0, 0, "R6");
        send_start(8'h40, 2, 8'h11);
        send_stop();
        settle();
        nack_addr = 0;
        chk(wq.size() == 0, "R6 payload of aborted frame drained", wq.size(), 0);
        chk(err_flag, "R7 flag set after address refusal", err_flag, 1);
        repeat (5) @(negedge clk);
        chk(err_flag, "R7 flag holds", err_flag, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(!err_flag, "R7 flag cleared", err_flag, 0);

        // R6: second write byte refused, then the next frame starts fresh.
        wr_idx = 0;
        nack_wr = 1;
        expect_prim(1, 0, 0, "R6");
        expect_prim(3, 8'h42, 0, "R6");
        expect_prim(4, 8'h70, 0, "R6");
        expect_prim(4, 8'h71, 0, "R6");
        expect_prim(6, 0, 0, "R6");
        send_start(8'h42, 3, 8'h70);
        send_stop();
        settle();
        nack_wr = -1;
        chk(wq.size() == 0, "R6 remaining write byte drained", wq.size(), 0);
        chk(err_flag, "R7 flag set after write refusal", err_flag, 1);
        expect_prim(1, 0, 0, "R6");
        expect_prim(3, 8'h30, 0, "R6");
        expect_prim(6, 0, 0, "R6");
        send_start(8'h30, 0, 8'h00);
        send_stop();
        settle();

        // R9: end marker with no open transfer.
        seen = cmd_seen;
        send_stop();
        repeat (20) @(negedge clk);
        chk(cmd_seen == seen && !eng_cmd_valid, "R9 stray end marker ignored", cmd_seen - seen, 0);

        finish_run();
    end

endmodule